// File: doc/BRIEF.md
# Serial Receive Engine with Control/Status Register

This block is the receive half of a serial port. It turns a stream on a single data pin into words of 8 or 9 bits and queues them in a small buffer for software. Two framings are handled. In asynchronous mode the line is oversampled on a baud tick and each frame has a start bit, data bits sent LSB first, and a stop bit. In synchronous master mode the block drives the shift clock itself and samples the data pin on each rising clock edge. In that mode it can take one word on request or keep receiving until told to stop.

Software controls the block through one 8-bit control/status register and pops words through a read port. The error flags and the ninth data bit in the register always describe the word at the head of the buffer. The one exception is the overrun flag. It latches and is cleared only by a specific write.

Top module: `serial_rx_port`

## Requirements
- R1: After reset the register reads 0x00, the buffer is empty, and the shift clock is neither driven nor enabled.
- R2: Register bit 3 always reads 0, whatever value is written to the register.
- R3: In asynchronous 8-bit mode (bit 7 = port enable, bit 4 = continuous enable, bit 6 = 0), a frame sent LSB first with a valid stop bit appears on `rd_data`, and `rd_valid` rises.
- R4: With bit 6 = 1, frames carry nine data bits. The ninth bit of the head word reads in register bit 0. In 8-bit mode bit 0 reads 0.
- R5: In asynchronous mode the single-receive bit (bit 5) has no effect. When only bit 5 is set, no word is received and the bit keeps its written value.
- R6: Register bit 2 is the framing flag of the head word. It reads 1 when that word's stop bit sampled low. After a pop it shows the flag of the next buffered word.
- R7: The buffer holds 2 words. A word that completes while the buffer is full is dropped, and this sets register bit 1. While bit 1 is set, reception stops. Bit 1 is cleared only by a register write with bit 4 = 0. A write with bit 4 = 1 leaves it set.
- R8: In synchronous master mode (`sync_sel` = 1) with only bit 5 set, exactly one word is clocked in. Hardware then clears bit 5 and the shift clock stays low.
- R9: In synchronous master mode with bit 4 set, words are clocked in back to back. Bit 5 is not cleared while bit 4 is set.
- R10: With bit 7 = 0, nothing is received and `sclk_oe` stays low. The shift clock output is low whenever `sclk_oe` is low.
- R11: An asynchronous data bit is taken as the majority of three oversamples around mid-bit. A low pulse shorter than half a bit on an idle line starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Oversample tick (async) or half-period tick of the shift clock (sync) |
| sync_sel | input | 1 | 1 = synchronous master mode, 0 = asynchronous |
| ctl_wr | input | 1 | Register write strobe |
| ctl_wdata | input | 8 | Register write data; bits 7..4 are writable |
| ctl_rdata | output | 8 | Register read value |
| rd_en | input | 1 | Pop the head word |
| rd_data | output | DATA_W | Head word data |
| rd_valid | output | 1 | Buffer holds at least one word |
| rx_pin | input | 1 | Serial data pin |
| sclk_out | output | 1 | Shift clock in synchronous master mode |
| sclk_oe | output | 1 | Enable for the shift clock output |

## Verification
A misaligned bit counter or oversample phase corrupts the word, and this shows on `rd_data` as soon as the frame's stop bit is sampled. A receiver that is left running after an overrun or after a disable causes extra words or stray clock edges on `sclk_out` within one word time. A wrong flag path shows up in register bits 2, 1 or 0 on the cycle after the push or pop that should have changed them. A hold on the overrun flag that is missing or too strong is caught one cycle after the register write.

// File: rtl/srx_pkg.sv
package srx_pkg;
   localparam int CTL_EN_B   = 7;
   localparam int CTL_NINE_B = 6;
   localparam int CTL_ONE_B  = 5;
   localparam int CTL_CONT_B = 4;
   localparam int CTL_FERR_B = 2;
   localparam int CTL_OVR_B  = 1;
   localparam int CTL_B9_B   = 0;

   typedef enum logic [1:0] {
      ARX_IDLE  = 2'd0,
      ARX_START = 2'd1,
      ARX_DATA  = 2'd2,
      ARX_STOP  = 2'd3
   } arx_state_e;
endpackage

// File: rtl/rx_buf.sv
module rx_buf #(
   parameter int W     = 10,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("rx_buf: DEPTH must be at least 1");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= nxt(wp);
         if (do_pop)  rp <= nxt(rp);
         if (do_push && !do_pop)      cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end
endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
   import srx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic              nine,
   input  logic              rx,
   output logic              done,
   output logic [DATA_W:0]   word,
   output logic              ferr
);
   localparam int PH_W    = $clog2(OSR);
   localparam int VOTE_PH = OSR / 2 + 1;
   localparam int IDX_W   = $clog2(DATA_W + 2);

   if (OSR < 4) begin : g_bad_osr
      $error("async_rx_core: OSR must be at least 4");
   end

   arx_state_e        st;
   logic [PH_W-1:0]   phase;
   logic [1:0]        smp;
   logic [IDX_W-1:0]  bidx, last_idx;
   logic [DATA_W:0]   shreg;
   logic              vote, at_vote;

   assign vote     = (smp[1] & smp[0]) | (smp[1] & rx) | (smp[0] & rx);
   assign at_vote  = (phase == PH_W'(VOTE_PH));
   assign last_idx = nine ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
   assign done     = en && tick && (st == ARX_STOP) && at_vote;
   assign ferr     = !vote;
   assign word     = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ARX_IDLE;
         phase <= '0;
         smp   <= 2'b11;
         bidx  <= '0;
         shreg <= '0;
      end else if (!en) begin
         st    <= ARX_IDLE;
         phase <= '0;
         smp   <= 2'b11;
         bidx  <= '0;
      end else if (tick) begin
         if (st == ARX_IDLE) begin
            if (!rx) begin
               st    <= ARX_START;
               phase <= PH_W'(1);
               smp   <= 2'b11;
            end
         end else begin
            smp   <= {smp[0], rx};
            phase <= (phase == PH_W'(OSR - 1)) ? '0 : phase + 1'b1;
            if (at_vote) begin
               case (st)
                  ARX_START: begin
                     if (vote) st <= ARX_IDLE;
                     else begin
                        st    <= ARX_DATA;
                        bidx  <= '0;
                        shreg <= '0;
                     end
                  end
                  ARX_DATA: begin
                     shreg <= shreg | ((DATA_W + 1)'(vote) << bidx);
                     if (bidx == last_idx) st <= ARX_STOP;
                     else                  bidx <= bidx + 1'b1;
                  end
                  default: st <= ARX_IDLE;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/sync_rx_core.sv
module sync_rx_core #(
   parameter int DATA_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            tick,
   input  logic            nine,
   input  logic            rx,
   output logic            done,
   output logic [DATA_W:0] word,
   output logic            sclk
);
   localparam int IDX_W = $clog2(DATA_W + 2);

   logic [IDX_W-1:0] cnt, nbits;
   logic [DATA_W:0]  shreg;

   assign nbits = nine ? IDX_W'(DATA_W + 1) : IDX_W'(DATA_W);
   assign done  = en && tick && sclk && (cnt == nbits);
   assign word  = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk  <= 1'b0;
         cnt   <= '0;
         shreg <= '0;
      end else if (!en) begin
         sclk  <= 1'b0;
         cnt   <= '0;
         shreg <= '0;
      end else if (tick) begin
         if (!sclk) begin
            sclk  <= 1'b1;
            shreg <= shreg | ((DATA_W + 1)'(rx) << cnt);
            cnt   <= cnt + 1'b1;
         end else begin
            sclk <= 1'b0;
            if (cnt == nbits) begin
               cnt   <= '0;
               shreg <= '0;
            end
         end
      end
   end
endmodule

// File: rtl/serial_rx_port.sv
module serial_rx_port
   import srx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OSR         = 16,
   parameter int BUF_DEPTH   = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              sync_sel,
   input  logic              ctl_wr,
   input  logic [7:0]        ctl_wdata,
   output logic [7:0]        ctl_rdata,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   input  logic              rx_pin,
   output logic              sclk_out,
   output logic              sclk_oe
);
   localparam int ENT_W = DATA_W + 2;

   if (DATA_W < 2) begin : g_bad_w
      $error("serial_rx_port: DATA_W must be at least 2");
   end

   logic rx_s;
   if (SYNC_STAGES == 0) begin : g_nosync
      assign rx_s = rx_pin;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= '1;
         else        sr <= {sr[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], rx_pin} & '1;
      end
      assign rx_s = sr[SYNC_STAGES-1];
   end

   logic port_en, nine_en, one_shot, cont_en, ovr;
   logic a_en, s_en, a_done, s_done, a_ferr, s_sclk;
   logic [DATA_W:0] a_word, s_word;
   logic push_req, buf_full, buf_empty;
   logic [ENT_W-1:0] ent_in, ent_out;

   assign a_en = port_en && !sync_sel && cont_en && !ovr;
   assign s_en = port_en && sync_sel && (cont_en || one_shot) && !ovr;

   async_rx_core #(.DATA_W(DATA_W), .OSR(OSR)) u_arx (
      .clk(clk), .rst_n(rst_n), .en(a_en), .tick(baud_tick), .nine(nine_en),
      .rx(rx_s), .done(a_done), .word(a_word), .ferr(a_ferr)
   );

   sync_rx_core #(.DATA_W(DATA_W)) u_srx (
      .clk(clk), .rst_n(rst_n), .en(s_en), .tick(baud_tick), .nine(nine_en),
      .rx(rx_pin), .done(s_done), .word(s_word), .sclk(s_sclk)
   );

   assign push_req = a_done || s_done;
   assign ent_in   = sync_sel ? {1'b0, s_word} : {a_ferr, a_word};

   rx_buf #(.W(ENT_W), .DEPTH(BUF_DEPTH)) u_buf (
      .clk(clk), .rst_n(rst_n), .push(push_req), .din(ent_in),
      .pop(rd_en), .dout(ent_out), .full(buf_full), .empty(buf_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_en  <= 1'b0;
         nine_en  <= 1'b0;
         one_shot <= 1'b0;
         cont_en  <= 1'b0;
         ovr      <= 1'b0;
      end else begin
         if (push_req && buf_full) ovr <= 1'b1;
         if (s_done && !cont_en)   one_shot <= 1'b0;
         if (ctl_wr) begin
            port_en  <= ctl_wdata[CTL_EN_B];
            nine_en  <= ctl_wdata[CTL_NINE_B];
            one_shot <= ctl_wdata[CTL_ONE_B];
            cont_en  <= ctl_wdata[CTL_CONT_B];
            if (!ctl_wdata[CTL_CONT_B]) ovr <= 1'b0;
         end
      end
   end

   assign rd_valid  = !buf_empty;
   assign rd_data   = ent_out[DATA_W-1:0];
   assign ctl_rdata = {port_en, nine_en, one_shot, cont_en, 1'b0,
                       ent_out[DATA_W+1] & !buf_empty, ovr,
                       ent_out[DATA_W] & !buf_empty};
   assign sclk_oe   = port_en && sync_sel;
   assign sclk_out  = s_sclk && sclk_oe;
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       ctl_wr,
   input logic [7:0] ctl_wdata,
   input logic [7:0] ctl_rdata,
   input logic       rd_valid,
   input logic       sclk_out,
   input logic       sclk_oe
);
   a_r2_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[3] == 1'b0);

   a_r10_no_oe_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rdata[7] |-> !sclk_oe);

   a_r10_clk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_oe |-> !sclk_out);

   a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata[1] && !(ctl_wr && !ctl_wdata[4])) |=> ctl_rdata[1]);

   a_r7_ovr_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_rdata[1]) |-> $past(rd_valid));

   a_r7_ovr_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_wdata[4]) |=> !ctl_rdata[1]);
endmodule

bind serial_rx_port serial_rx_checker u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
   .ctl_rdata(ctl_rdata), .rd_valid(rd_valid), .sclk_out(sclk_out),
   .sclk_oe(sclk_oe)
);

// File: tb/tb_serial_rx_port.sv
module tb_serial_rx_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b1;
   logic       sync_sel = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = 8'h00;
   logic [7:0] ctl_rdata;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       rd_valid;
   logic       rx_pin = 1'b1;
   logic       sclk_out, sclk_oe;
   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   serial_rx_port dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .sync_sel(sync_sel),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .rx_pin(rx_pin),
      .sclk_out(sclk_out), .sclk_oe(sclk_oe)
   );

   // {nine_mode, stop_ok, data[8:0]}
   localparam logic [10:0] VEC [0:4] = '{
      {1'b0, 1'b1, 9'h0A5},
      {1'b1, 1'b1, 9'h13C},
      {1'b1, 1'b0, 9'h0FF},
      {1'b0, 1'b0, 9'h000},
      {1'b1, 1'b1, 9'h001}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_ctl(input logic [7:0] v);
      @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk); ctl_wr = 1'b0;
   endtask

   task automatic pop();
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic send_async(input logic [8:0] d, input int n, input logic stop);
      @(negedge clk); rx_pin = 1'b0;
      repeat (16) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         rx_pin = d[i];
         repeat (16) @(negedge clk);
      end
      rx_pin = stop;
      repeat (16) @(negedge clk);
      rx_pin = 1'b1;
      repeat (24) @(negedge clk);
   endtask

   // Drives nb bits LSB first, changing data after each falling shift clock edge.
   task automatic drive_sync(input logic [15:0] bits, input int nb);
      for (int j = 1; j < nb; j++) begin
         @(negedge sclk_out); #1 rx_pin = bits[j];
      end
      @(negedge sclk_out);
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 reg", 16'(ctl_rdata), 16'h00);
      chk("R1 valid", 16'(rd_valid), 16'h0);
      chk("R1 oe", 16'({sclk_oe, sclk_out}), 16'h0);

      // R3 / R4 / R6 table walk
      for (int k = 0; k < 5; k++) begin
         wr_ctl(VEC[k][10] ? 8'hD0 : 8'h90);
         send_async(VEC[k][8:0], VEC[k][10] ? 9 : 8, VEC[k][9]);
         chk("R3 valid", 16'(rd_valid), 16'h1);
         chk("R3 data", 16'(rd_data), 16'(VEC[k][7:0]));
         chk("R4 ninth", 16'(ctl_rdata[0]), VEC[k][10] ? 16'(VEC[k][8]) : 16'h0);
         chk("R6 ferr", 16'(ctl_rdata[2]), 16'(!VEC[k][9]));
         pop();
         chk("R3 popped", 16'(rd_valid), 16'h0);
      end

      // R2 unimplemented bit
      wr_ctl(8'hFF);
      chk("R2 bit3", 16'(ctl_rdata & 8'h08), 16'h0);
      chk("R2 low bits", 16'(ctl_rdata & 8'h0F), 16'h0);

      // R11 short glitch on idle line starts nothing; next frame intact
      wr_ctl(8'h90);
      @(negedge clk); rx_pin = 1'b0;
      repeat (5) @(negedge clk); rx_pin = 1'b1;
      repeat (40) @(negedge clk);
      chk("R11 glitch", 16'(rd_valid), 16'h0);
      send_async(9'h05A, 8, 1'b1);
      chk("R11 data", 16'(rd_data), 16'h5A);
      pop();

      // R6 flag follows head word
      send_async(9'h055, 8, 1'b0);
      send_async(9'h066, 8, 1'b1);
      chk("R6 head bad", 16'({ctl_rdata[2], rd_data}), 16'h155);
      pop();
      chk("R6 next good", 16'({ctl_rdata[2], rd_data}), 16'h066);
      pop();

      // R5 single enable ignored in async mode
      wr_ctl(8'hA0);
      send_async(9'h0C3, 8, 1'b1);
      chk("R5 no word", 16'(rd_valid), 16'h0);
      chk("R5 bit kept", 16'(ctl_rdata[5]), 16'h1);

      // R7 overrun
      wr_ctl(8'h90);
      send_async(9'h011, 8, 1'b1);
      send_async(9'h022, 8, 1'b1);
      chk("R7 no ovr yet", 16'(ctl_rdata[1]), 16'h0);
      send_async(9'h033, 8, 1'b1);
      chk("R7 ovr set", 16'(ctl_rdata[1]), 16'h1);
      chk("R7 head kept", 16'(rd_data), 16'h11);
      send_async(9'h044, 8, 1'b1);
      wr_ctl(8'h90);
      chk("R7 ovr sticky", 16'(ctl_rdata[1]), 16'h1);
      pop();
      chk("R7 second", 16'(rd_data), 16'h22);
      pop();
      chk("R7 dropped", 16'(rd_valid), 16'h0);
      wr_ctl(8'h80);
      chk("R7 ovr cleared", 16'(ctl_rdata[1]), 16'h0);

      // R10 port disabled
      wr_ctl(8'h10);
      send_async(9'h0AA, 8, 1'b1);
      chk("R10 no word", 16'(rd_valid), 16'h0);
      sync_sel = 1'b1;
      wr_ctl(8'h30);
      repeat (10) @(negedge clk);
      chk("R10 oe", 16'({sclk_oe, sclk_out}), 16'h0);
      chk("R10 no sync word", 16'(rd_valid), 16'h0);

      // R8 synchronous single word
      wr_ctl(8'h80);
      rx_pin = 1'b1; // bit0 of 0xB5
      wr_ctl(8'hA0);
      drive_sync(16'h00B5, 8);
      repeat (3) @(negedge clk);
      chk("R8 data", 16'(rd_data), 16'hB5);
      chk("R8 bit cleared", 16'(ctl_rdata[5]), 16'h0);
      chk("R8 oe", 16'(sclk_oe), 16'h1);
      begin
         logic seen = 1'b0;
         repeat (20) begin @(negedge clk); seen |= sclk_out; end
         chk("R8 clock idle", 16'(seen), 16'h0);
      end
      pop();
      chk("R8 one word", 16'(rd_valid), 16'h0);

      // R9 continuous overrides single
      rx_pin = 1'b0; // bit0 of 0x3C
      wr_ctl(8'hB0);
      drive_sync(16'hC33C, 16);
      chk("R9 single kept", 16'(ctl_rdata[5]), 16'h1);
      wr_ctl(8'h80);
      chk("R9 first", 16'(rd_data), 16'h3C);
      pop();
      chk("R9 second", 16'(rd_data), 16'hC3);
      pop();
      chk("R9 empty", 16'(rd_valid), 16'h0);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule